// File: doc/BRIEF.md
# Resolution-Scaled Conversion Scheduler

This block paces the periodic conversions of a temperature sensing front end and owns the result register. Time is counted in units of an external tick input, which the surrounding logic drives with a prescaled strobe (nominally one per millisecond). The block starts conversions one after another. Each conversion takes a time set by the selected resolution. At its end, a raw 13-bit sample is taken from an input port, the low-order bits that the chosen resolution does not resolve are cleared, and a one-cycle completion strobe is raised.

The spacing between conversion starts comes from a delay selection, given for full 12-bit resolution. It shrinks by the same power of two as the conversion time when a coarser resolution is selected. The resolution and delay settings are captured when each conversion starts. A shutdown request never cuts a conversion short: the running conversion finishes and stores its result, and then no new conversion starts until the request is withdrawn.

Top module: `conv_sched`

## Requirements
- R1: After reset, temp_reg reads 0, conv_done is 0 and busy is 0 until the first conversion starts, and temp_reg stays 0 until the first conversion completes.
- R2: A conversion occupies CONV_BASE << res_code ticks. Resolution codes 0,1,2,3 select 9,10,11,12 bits. busy is high from the conversion start until the tick that completes it, and busy falls only at a completion.
- R3: Between consecutive conversion starts, with no shutdown in between, exactly (P[dly_code] >> (3 - res_code)) ticks elapse. Delay codes 0,1,2,3 select P0,P1,P2,P3, which are the 12-bit periods.
- R4: The stored result is raw_sample with its lowest (3 - res_code) bits forced to 0. At code 3 all 13 bits are kept.
- R5: temp_reg changes only in the cycle where conv_done is high, and it holds its value while raw_sample changes between completions.
- R6: A shutdown request raised during a conversion, including in the very cycle the final tick is consumed, lets that conversion complete and store its result. After that, busy stays 0 while the request stays high.
- R7: When shutdown_req falls while no conversion is running, a conversion starts on the next clock edge (busy is high one cycle later).
- R8: res_code and dly_code are sampled at the conversion start. A change during a conversion affects neither its length, its masking, nor the period up to the next start.
- R9: conv_done is a single-cycle pulse and is asserted once per completed conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Time base strobe; one tick is one unit of conversion and period time |
| res_code | input | 2 | Resolution select: 0=9, 1=10, 2=11, 3=12 bits |
| dly_code | input | 2 | Start-to-start period select (12-bit values P0..P3) |
| shutdown_req | input | 1 | Stop after the running conversion; release starts a new one |
| raw_sample | input | 13 | Raw converter result, taken at completion |
| temp_reg | output | 13 | Last completed, masked result |
| conv_done | output | 1 | One-cycle strobe after a conversion completes |
| busy | output | 1 | High while a conversion is in progress |

## Verification
Three things can meet in the same clock edge: the completion of a conversion, the arrival of a shutdown request, and the end of the period. The bench counts ticks while busy is high. In the cycle where the final tick of a 9-bit conversion is about to be consumed, it raises shutdown_req. At that resolution the period is only one tick longer than the conversion, so a wrong ordering would quickly show up as an extra start. The scoreboard expects the completion and its masked value first, and then busy held low for many periods. Separate runs change res_code in the middle of a conversion, to show that the settings captured at the start decide the masking, the length and the next start time.

// File: rtl/conv_sched_pkg.sv
package conv_sched_pkg;

  localparam int RES_W = 2;
  localparam int DLY_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_WAIT = 2'd2
  } sched_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/conv_sched_rstsync.sv
module conv_sched_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/conv_sched_timing.sv
module conv_sched_timing
  import conv_sched_pkg::*;
#(
  parameter int CONV_BASE = 30,
  parameter int PER0      = 250,
  parameter int PER1      = 500,
  parameter int PER2      = 1000,
  parameter int PER3      = 8000,
  parameter int CNT_W     = 15
) (
  input  logic [RES_W-1:0] res_code,
  input  logic [DLY_W-1:0] dly_code,
  output logic [CNT_W-1:0] conv_len,
  output logic [CNT_W-1:0] per_len
);

  localparam int MAX_CODE = (1 << RES_W) - 1;
  localparam logic [CNT_W-1:0] PER_TAB [4] = '{
    CNT_W'(PER0), CNT_W'(PER1), CNT_W'(PER2), CNT_W'(PER3)
  };

  logic [RES_W-1:0] drop;
  logic [CNT_W-1:0] per_full;

  always_comb begin
    drop     = RES_W'(MAX_CODE) - res_code;
    per_full = PER_TAB[dly_code];
    per_len  = per_full >> drop;
    conv_len = CNT_W'(CONV_BASE) << res_code;
  end

endmodule

// File: rtl/conv_sched_fsm.sv
module conv_sched_fsm
  import conv_sched_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sd_req,
  input  logic [CNT_W-1:0] conv_len,
  input  logic [CNT_W-1:0] per_len,
  output logic             busy,
  output logic             start,
  output logic             finish
);

  sched_state_t     st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] clen_q, clen_d;
  logic [CNT_W-1:0] plen_q, plen_d;
  logic [CNT_W-1:0] cnt_inc;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    clen_d  = clen_q;
    plen_d  = plen_q;
    start   = 1'b0;
    finish  = 1'b0;
    cnt_inc = cnt_q + 1'b1;
    unique case (st_q)
      ST_IDLE: begin
        if (!sd_req) start = 1'b1;
      end
      ST_CONV: begin
        if (tick) begin
          cnt_d = cnt_inc;
          if (cnt_inc >= clen_q) begin
            finish = 1'b1;
            if (sd_req)                 st_d  = ST_IDLE;
            else if (cnt_inc >= plen_q) start = 1'b1;
            else                        st_d  = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (sd_req) begin
          st_d = ST_IDLE;
        end else if (tick) begin
          cnt_d = cnt_inc;
          if (cnt_inc >= plen_q) start = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (start) begin
      st_d   = ST_CONV;
      cnt_d  = '0;
      clen_d = conv_len;
      plen_d = per_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      clen_q <= '0;
      plen_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      clen_q <= clen_d;
      plen_q <= plen_d;
    end
  end

  assign busy = (st_q == ST_CONV);

endmodule

// File: rtl/conv_sched_result.sv
module conv_sched_result
  import conv_sched_pkg::*;
#(
  parameter int SAMPLE_W = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [RES_W-1:0]    res_code,
  input  logic                finish,
  input  logic [SAMPLE_W-1:0] raw_sample,
  output logic [SAMPLE_W-1:0] temp_reg,
  output logic                conv_done
);

  localparam int MAX_CODE = (1 << RES_W) - 1;

  logic [RES_W-1:0]    res_q, res_d;
  logic [SAMPLE_W-1:0] temp_q, temp_d;
  logic                done_q, done_d;
  logic [SAMPLE_W-1:0] keep;
  logic [RES_W-1:0]    drop;

  assign drop = RES_W'(MAX_CODE) - res_q;

  for (genvar i = 0; i < SAMPLE_W; i++) begin : g_keep
    assign keep[i] = (i >= int'(drop));
  end

  always_comb begin
    res_d  = start  ? res_code : res_q;
    temp_d = finish ? (raw_sample & keep) : temp_q;
    done_d = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= RES_W'(MAX_CODE);
      temp_q <= '0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      temp_q <= temp_d;
      done_q <= done_d;
    end
  end

  assign temp_reg  = temp_q;
  assign conv_done = done_q;

endmodule

// File: rtl/conv_sched.sv
module conv_sched
  import conv_sched_pkg::*;
#(
  parameter int SAMPLE_W  = 13,
  parameter int CONV_BASE = 30,
  parameter int PER0      = 250,
  parameter int PER1      = 500,
  parameter int PER2      = 1000,
  parameter int PER3      = 8000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [1:0]          res_code,
  input  logic [1:0]          dly_code,
  input  logic                shutdown_req,
  input  logic [SAMPLE_W-1:0] raw_sample,
  output logic [SAMPLE_W-1:0] temp_reg,
  output logic                conv_done,
  output logic                busy
);

  localparam int MAX_T = max_of(max_of(max_of(PER0, PER1), max_of(PER2, PER3)),
                                CONV_BASE << ((1 << RES_W) - 1));
  localparam int CNT_W = $clog2(MAX_T + 1) + 1;

  logic             rst_n_i;
  logic [CNT_W-1:0] conv_len, per_len;
  logic             start, finish;

  conv_sched_rstsync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  conv_sched_timing #(
    .CONV_BASE (CONV_BASE),
    .PER0      (PER0),
    .PER1      (PER1),
    .PER2      (PER2),
    .PER3      (PER3),
    .CNT_W     (CNT_W)
  ) u_timing (
    .res_code (res_code),
    .dly_code (dly_code),
    .conv_len (conv_len),
    .per_len  (per_len)
  );

  conv_sched_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .tick     (tick),
    .sd_req   (shutdown_req),
    .conv_len (conv_len),
    .per_len  (per_len),
    .busy     (busy),
    .start    (start),
    .finish   (finish)
  );

  conv_sched_result #(.SAMPLE_W(SAMPLE_W)) u_result (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (start),
    .res_code   (res_code),
    .finish     (finish),
    .raw_sample (raw_sample),
    .temp_reg   (temp_reg),
    .conv_done  (conv_done)
  );

endmodule

// File: rtl/conv_sched_chk.sv
module conv_sched_chk #(
  parameter int SAMPLE_W = 13
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          res_code,
  input logic                shutdown_req,
  input logic [SAMPLE_W-1:0] temp_reg,
  input logic                conv_done,
  input logic                busy
);

  logic [1:0] res_prev, res_start;
  logic       busy_prev;
  logic [SAMPLE_W-1:0] low_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_prev  <= 2'd3;
      res_start <= 2'd3;
      busy_prev <= 1'b0;
    end else begin
      res_prev  <= res_code;
      busy_prev <= busy;
      if (busy && !busy_prev) res_start <= res_prev;
    end
  end

  assign low_bits = ~({SAMPLE_W{1'b1}} << (2'd3 - res_start));

  // R4
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> ((temp_reg & low_bits) == '0));

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_reg != $past(temp_reg)) |-> conv_done);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> conv_done);

  // R6
  shutdown_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req && !busy) |=> !busy);

  // R7
  release_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(shutdown_req) && !busy) |=> busy);

endmodule

bind conv_sched conv_sched_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_code     (res_code),
  .shutdown_req (shutdown_req),
  .temp_reg     (temp_reg),
  .conv_done    (conv_done),
  .busy         (busy)
);

// File: tb/conv_sched_bench.sv
module conv_sched_bench;

  localparam int CB = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [1:0]  res_code, dly_code;
  logic        shutdown_req;
  logic [12:0] raw_sample;
  logic [12:0] temp_reg;
  logic        conv_done, busy;

  always #10 clk = ~clk;

  conv_sched #(
    .SAMPLE_W(13), .CONV_BASE(CB), .PER0(32), .PER1(64), .PER2(128), .PER3(256)
  ) u_conv_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick), .res_code(res_code), .dly_code(dly_code),
    .shutdown_req(shutdown_req), .raw_sample(raw_sample), .temp_reg(temp_reg),
    .conv_done(conv_done), .busy(busy)
  );

  typedef struct { logic [12:0] val; int conv; } exp_t;
  exp_t q[$];
  int   exp_per;
  int   checks = 0;
  int   fails  = 0;

  function automatic int conv_t(input logic [1:0] r);
    return CB << r;
  endfunction
  function automatic int per_t(input logic [1:0] d, input logic [1:0] r);
    return (32 << d) >> (3 - r);
  endfunction
  function automatic logic [12:0] msk(input logic [12:0] s, input logic [1:0] r);
    return s & (13'h1FFF << (2'd3 - r));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // tick: toggles shortly after each rising edge, so it is high every other cycle
  initial begin
    tick = 1'b0;
    forever begin
      @(posedge clk);
      #5 tick = ~tick;
    end
  end

  // monitor / scoreboard
  logic prev_busy = 1'b0, prev_done = 1'b0, seen_start = 1'b0;
  int   conv_ticks = 0, per_ticks = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_done) check(!conv_done, "R9 done width", int'(conv_done), 0);
      if (busy && !prev_busy) begin
        if (seen_start && !shutdown_req) check(per_ticks == exp_per, "R3 start period", per_ticks, exp_per);
        seen_start = 1'b1;
        per_ticks  = int'(tick);
        conv_ticks = int'(tick);
      end else begin
        per_ticks += int'(tick);
        if (busy) conv_ticks += int'(tick);
      end
      if (shutdown_req) seen_start = 1'b0;
      if (conv_done) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(temp_reg == e.val, "R4 R8 masked value", int'(temp_reg), int'(e.val));
          check(conv_ticks == e.conv, "R2 R8 conversion ticks", conv_ticks, e.conv);
        end
      end
      prev_busy = busy;
      prev_done = conv_done;
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!conv_done);
  endtask

  task automatic run_pair(input logic [1:0] r1, input logic [1:0] r2, input logic [1:0] d,
                          input logic [12:0] s1, input logic [12:0] s2);
    int seen_busy;
    @(negedge clk);
    res_code = r1; dly_code = d; raw_sample = s1;
    q.push_back('{msk(s1, r1), conv_t(r1)});
    exp_per = per_t(d, r1);
    shutdown_req = 1'b0;
    @(negedge clk);
    check(busy, "R7 start after release", int'(busy), 1);
    @(negedge clk);
    res_code = r2;                       // R8: mid-conversion change
    wait_done();
    @(negedge clk);
    raw_sample = s2;
    q.push_back('{msk(s2, r2), conv_t(r2)});
    while (!busy) @(negedge clk);
    @(negedge clk);
    shutdown_req = 1'b1;                 // R6: request during conversion
    wait_done();
    @(negedge clk);
    raw_sample = ~s2;                    // R5: input moves, register must not
    seen_busy = 0;
    repeat (4 * per_t(d, r2) + 8) begin
      @(negedge clk);
      if (busy) seen_busy++;
    end
    check(seen_busy == 0, "R6 no start in shutdown", seen_busy, 0);
    check(temp_reg == msk(s2, r2), "R5 result held", int'(temp_reg), int'(msk(s2, r2)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int busy_cnt;
    rst_n = 1'b0; shutdown_req = 1'b1; res_code = 2'd3; dly_code = 2'd0; raw_sample = 13'h1555;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(temp_reg == 13'd0, "R1 reset value", int'(temp_reg), 0);
    check(!conv_done, "R1 no done", int'(conv_done), 0);
    check(!busy, "R1 idle while held", int'(busy), 0);

    run_pair(2'd3, 2'd0, 2'd0, 13'h1A5F, 13'h0777);
    run_pair(2'd0, 2'd2, 2'd1, 13'h0B3D, 13'h1FFF);
    run_pair(2'd1, 2'd3, 2'd3, 13'h12C6, 13'h0ACB);
    run_pair(2'd2, 2'd1, 2'd2, 13'h1F0F, 13'h0F3B);

    // R6: shutdown raised in the cycle the final tick is consumed
    @(negedge clk);
    res_code = 2'd0; dly_code = 2'd0; raw_sample = 13'h1BEF;
    q.push_back('{msk(13'h1BEF, 2'd0), conv_t(2'd0)});
    exp_per = per_t(2'd0, 2'd0);
    shutdown_req = 1'b0;
    n = 0;
    forever begin
      @(negedge clk);
      if (busy && tick) begin
        n++;
        if (n == conv_t(2'd0)) begin
          shutdown_req = 1'b1;
          break;
        end
      end
    end
    @(negedge clk);
    check(conv_done, "R6 completion on coincident request", int'(conv_done), 1);
    busy_cnt = 0;
    repeat (40) begin
      @(negedge clk);
      if (busy) busy_cnt++;
    end
    check(busy_cnt == 0, "R6 no restart after coincident request", busy_cnt, 0);
    check(temp_reg == msk(13'h1BEF, 2'd0), "R6 result stored", int'(temp_reg), int'(msk(13'h1BEF, 2'd0)));
    check(q.size() == 0, "R9 every conversion completed once", q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule